// File: doc/BRIEF.md
# Multi-Format Serial Audio Input Receiver

This block receives serial audio from an external master. The master drives the bit clock, the word select and up to four data lines. The block is always a slave: every register runs on the rising edge of the incoming bit clock, and word select and the data lines are sampled on that edge. The four data lines share one bit clock and one word select, so the block carries eight channels: a left and a right channel on each line.

Two framing styles are supported. In the standard I2S style the first (most significant) bit of a word comes one bit clock after the word-select change. In the LSB-justified style the last (least significant) bit sits on the final bit clock before the change. A configuration input selects the word length as 16, 18, 20 or 24 bits. Every word is delivered as a 24-bit value aligned to the top bit, with zeros below its least significant bit.

When a frame completes, the block presents the left and right samples of all four lines together and raises a one-cycle valid strobe. Two error strobes report word-select periods that are too long, and halves of unequal length in LSB-justified mode.

Top module: `ser_audio_rx`

## Requirements
- R1: While reset is active, and after its synchronous release until the first frame completes, every sample output, the valid strobe and both error strobes read zero.
- R2: With `cfg_lsbj_i`=0 (I2S), the bit sampled on the first bit-clock edge after word select changes is the word's MSB. Word select low carries the left channel and high carries the right channel.
- R3: With `cfg_lsbj_i`=1 (LSB-justified), the bit sampled on the last bit-clock edge before a word-select change is the word's LSB, and the word is the configured number of bits ending there.
- R4: `cfg_wlen_i` codes 0, 1, 2 and 3 select 16, 18, 20 and 24 bits. The word is placed with its MSB at output bit 23, and all bits below its LSB are zero.
- R5: In I2S mode, bits that follow the configured word length within the same half are ignored. A word longer than 24 bits therefore keeps its 24 MSBs.
- R6: In LSB-justified mode, bits in a half that come before the word's MSB are ignored.
- R7: Data line n feeds output bits [24n+23:24n] of both `smp_left_o` and `smp_right_o`. The lines are handled independently.
- R8: `smp_valid_o` pulses for exactly one bit clock once each right word completes, provided a complete left word came before it, and all eight outputs update on that same edge. A frame that is only partly seen after reset produces no pulse.
- R9: `err_len_o` pulses when a word-select period (a low half followed by a high half) holds more than 256 bit clocks, on the edge where word select falls. A period of exactly 256 bit clocks is not flagged.
- R10: `err_sym_o` pulses in LSB-justified mode when the low and high halves of a period differ in bit-clock count. It never pulses in I2S mode.
- R11: Between valid pulses the sample outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bck_i | input | 1 | Bit clock from the external master; all logic uses its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ws_i | input | 1 | Word select from the master; low = left, high = right |
| sd_i | input | NUM_LINES | Serial data lines, MSB first |
| cfg_lsbj_i | input | 1 | Framing select: 0 = I2S, 1 = LSB-justified |
| cfg_wlen_i | input | 2 | Word length code: 0=16, 1=18, 2=20, 3=24 bits |
| smp_left_o | output | NUM_LINES*24 | Left samples, 24 bits per line, top-aligned |
| smp_right_o | output | NUM_LINES*24 | Right samples, 24 bits per line, top-aligned |
| smp_valid_o | output | 1 | One-cycle strobe when a full frame has been delivered |
| err_len_o | output | 1 | One-cycle strobe: word-select period longer than 256 bit clocks |
| err_sym_o | output | 1 | One-cycle strobe: unequal halves in LSB-justified mode |

## Verification
The embedded assertions check four properties on every bit clock:
- the valid strobe never lasts two edges;
- the sample registers never move without the strobe;
- a length error only appears on the edge where the sampled word select falls;
- a symmetry error only appears in LSB-justified mode.

Whether the right bits land in the right place can only be shown by the directed scenarios. These cover the position of the MSB and LSB in each framing style, zero fill for each word-length code, truncation of 32-bit words, dropping of padding bits, independence of the lines, and the exact 256/260 limit of the length check.

// File: rtl/ser_audio_rx_pkg.sv
package ser_audio_rx_pkg;

  // Output sample width; the four word-length codes top out at this value.
  localparam int unsigned SMP_W = 24;

  typedef enum logic [1:0] {
    WL16 = 2'd0,
    WL18 = 2'd1,
    WL20 = 2'd2,
    WL24 = 2'd3
  } wlen_e;

  // Per-edge controls broadcast from the framer to every data lane.
  typedef struct packed {
    logic shift_en;  // shift the sampled bit into the lane register
    logic clr;       // restart the lane register with this bit (I2S word start)
    logic cap_left;  // a left word just ended: stage it
    logic commit;    // a right word just ended after a staged left: publish
  } lane_ctl_t;

  function automatic int unsigned wlen_bits(input wlen_e w);
    case (w)
      WL16:    return 16;
      WL18:    return 18;
      WL20:    return 20;
      default: return 24;
    endcase
  endfunction

endpackage

// File: rtl/ser_audio_rx_rst_sync.sv
module ser_audio_rx_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[1];

endmodule

// File: rtl/ser_audio_rx_framer.sv
module ser_audio_rx_framer
  import ser_audio_rx_pkg::*;
#(
  parameter int unsigned SW = SMP_W
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      ws_i,
  input  logic      lsbj_i,
  input  wlen_e     wlen_i,
  output lane_ctl_t ctl_o,
  output logic      valid_o,
  output logic      ws_q_o
);

  localparam int unsigned IDX_W = $clog2(SW + 1);

  logic             ws_q, ws_d;
  logic             ws_qq, ws_qd;
  logic             have_start_q, have_start_d;
  logic             left_ok_q, left_ok_d;
  logic             valid_q, valid_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  logic             raw_tr;
  logic             bnd;
  logic             old_right;
  logic [IDX_W-1:0] wbits;

  always_comb begin
    raw_tr    = ws_i ^ ws_q;
    // I2S words start one bit after the select change: use the delayed copy.
    bnd       = lsbj_i ? raw_tr : (ws_q ^ ws_qq);
    old_right = lsbj_i ? ws_q : ws_qq;
    wbits     = IDX_W'(wlen_bits(wlen_i));

    ws_d  = ws_i;
    ws_qd = ws_q;

    idx_d = idx_q;
    if (bnd)                idx_d = IDX_W'(1);
    else if (idx_q < wbits) idx_d = idx_q + IDX_W'(1);

    ctl_o.clr      = bnd && !lsbj_i;
    ctl_o.shift_en = lsbj_i || (idx_q < wbits);
    ctl_o.cap_left = bnd && !old_right;
    ctl_o.commit   = bnd && old_right && left_ok_q;

    have_start_d = have_start_q | bnd;

    left_ok_d = left_ok_q;
    if (ctl_o.cap_left) left_ok_d = have_start_q;
    else if (bnd)       left_ok_d = 1'b0;

    valid_d = ctl_o.commit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ws_q         <= 1'b0;
      ws_qq        <= 1'b0;
      have_start_q <= 1'b0;
      left_ok_q    <= 1'b0;
      valid_q      <= 1'b0;
      idx_q        <= '0;
    end else begin
      ws_q         <= ws_d;
      ws_qq        <= ws_qd;
      have_start_q <= have_start_d;
      left_ok_q    <= left_ok_d;
      valid_q      <= valid_d;
      idx_q        <= idx_d;
    end
  end

  assign valid_o = valid_q;
  assign ws_q_o  = ws_q;

  AST_VALID_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q); // R8

endmodule

// File: rtl/ser_audio_rx_frame_chk.sv
module ser_audio_rx_frame_chk #(
  parameter int unsigned MAX_BCK = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ws_i,
  input  logic ws_q_i,
  input  logic lsbj_i,
  output logic err_len_o,
  output logic err_sym_o
);

  localparam int unsigned CNT_W = $clog2(MAX_BCK) + 1;
  localparam int unsigned SUM_W = CNT_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] half_q, half_d;
  logic [CNT_W-1:0] low_q, low_d;
  logic             low_ok_q, low_ok_d;
  logic             seen_q, seen_d;
  logic             elen_q, elen_d;
  logic             esym_q, esym_d;

  logic             raw_tr;
  logic [SUM_W-1:0] period;

  always_comb begin
    raw_tr   = ws_i ^ ws_q_i;
    period   = {1'b0, low_q} + {1'b0, half_q};
    half_d   = half_q;
    low_d    = low_q;
    low_ok_d = low_ok_q;
    seen_d   = seen_q;
    elen_d   = 1'b0;
    esym_d   = 1'b0;

    if (raw_tr) begin
      half_d = CNT_W'(1);
      seen_d = 1'b1;
      if (ws_i) begin
        // low half just ended; only trusted if it began at a seen transition
        low_d    = half_q;
        low_ok_d = seen_q;
      end else begin
        if (low_ok_q) begin
          elen_d = (period > SUM_W'(MAX_BCK));
          esym_d = lsbj_i && (low_q != half_q);
        end
        low_ok_d = 1'b0;
      end
    end else if (half_q != CNT_MAX) begin
      half_d = half_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q   <= '0;
      low_q    <= '0;
      low_ok_q <= 1'b0;
      seen_q   <= 1'b0;
      elen_q   <= 1'b0;
      esym_q   <= 1'b0;
    end else begin
      half_q   <= half_d;
      low_q    <= low_d;
      low_ok_q <= low_ok_d;
      seen_q   <= seen_d;
      elen_q   <= elen_d;
      esym_q   <= esym_d;
    end
  end

  assign err_len_o = elen_q;
  assign err_sym_o = esym_q;

  AST_LEN_AT_WS_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    elen_q |-> (!ws_q_i && $past(ws_q_i))); // R9

  AST_SYM_LSBJ_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    esym_q |-> $past(lsbj_i)); // R10

endmodule

// File: rtl/ser_audio_rx_lane.sv
module ser_audio_rx_lane
  import ser_audio_rx_pkg::*;
#(
  parameter int unsigned SW = SMP_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sd_i,
  input  wlen_e         wlen_i,
  input  lane_ctl_t     ctl_i,
  input  logic          valid_i,
  output logic [SW-1:0] left_o,
  output logic [SW-1:0] right_o
);

  logic [SW-1:0] sh_q, sh_d;
  logic [SW-1:0] stage_q, stage_d;
  logic [SW-1:0] l_q, l_d;
  logic [SW-1:0] r_q, r_d;
  logic [SW-1:0] cap;

  always_comb begin
    // Low bits of the shift register hold the finished word; top-align it.
    cap = sh_q << (SW - wlen_bits(wlen_i));

    if (ctl_i.clr)           sh_d = {{(SW-1){1'b0}}, sd_i};
    else if (ctl_i.shift_en) sh_d = {sh_q[SW-2:0], sd_i};
    else                     sh_d = sh_q;

    stage_d = ctl_i.cap_left ? cap : stage_q;
    l_d     = ctl_i.commit ? stage_q : l_q;
    r_d     = ctl_i.commit ? cap : r_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      stage_q <= '0;
      l_q     <= '0;
      r_q     <= '0;
    end else begin
      sh_q    <= sh_d;
      stage_q <= stage_d;
      l_q     <= l_d;
      r_q     <= r_d;
    end
  end

  assign left_o  = l_q;
  assign right_o = r_q;

  AST_OUT_HOLD_LEFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> $stable(l_q)); // R11

  AST_OUT_HOLD_RIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> $stable(r_q)); // R11

endmodule

// File: rtl/ser_audio_rx.sv
module ser_audio_rx
  import ser_audio_rx_pkg::*;
#(
  parameter int unsigned NUM_LINES = 4,
  parameter int unsigned MAX_BCK   = 256
) (
  input  logic                       bck_i,
  input  logic                       rst_ni,
  input  logic                       ws_i,
  input  logic [NUM_LINES-1:0]       sd_i,
  input  logic                       cfg_lsbj_i,
  input  logic [1:0]                 cfg_wlen_i,
  output logic [NUM_LINES*SMP_W-1:0] smp_left_o,
  output logic [NUM_LINES*SMP_W-1:0] smp_right_o,
  output logic                       smp_valid_o,
  output logic                       err_len_o,
  output logic                       err_sym_o
);

  localparam int unsigned SW = SMP_W;

  logic      rst_n;
  logic      ws_q;
  lane_ctl_t ctl;
  wlen_e     wlen;

  assign wlen = wlen_e'(cfg_wlen_i);

  ser_audio_rx_rst_sync u_rst (
    .clk_i  (bck_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  ser_audio_rx_framer #(.SW(SW)) u_framer (
    .clk_i   (bck_i),
    .rst_ni  (rst_n),
    .ws_i    (ws_i),
    .lsbj_i  (cfg_lsbj_i),
    .wlen_i  (wlen),
    .ctl_o   (ctl),
    .valid_o (smp_valid_o),
    .ws_q_o  (ws_q)
  );

  ser_audio_rx_frame_chk #(.MAX_BCK(MAX_BCK)) u_chk (
    .clk_i     (bck_i),
    .rst_ni    (rst_n),
    .ws_i      (ws_i),
    .ws_q_i    (ws_q),
    .lsbj_i    (cfg_lsbj_i),
    .err_len_o (err_len_o),
    .err_sym_o (err_sym_o)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_lane
    ser_audio_rx_lane #(.SW(SW)) u_lane (
      .clk_i   (bck_i),
      .rst_ni  (rst_n),
      .sd_i    (sd_i[g]),
      .wlen_i  (wlen),
      .ctl_i   (ctl),
      .valid_i (smp_valid_o),
      .left_o  (smp_left_o[g*SW +: SW]),
      .right_o (smp_right_o[g*SW +: SW])
    );
  end

endmodule

// File: tb/tb_ser_audio_rx.sv
module tb_ser_audio_rx;

  localparam int CLK_PERIOD = 10;
  localparam int NL   = 4;
  localparam int MAXT = 2048;

  logic          bck = 1'b0;
  logic          rst_n;
  logic          ws;
  logic [NL-1:0] sd;
  logic          lsbj;
  logic [1:0]    wlen;
  logic [NL*24-1:0] smp_l, smp_r;
  logic          valid, elen, esym;

  int checks = 0;
  int failures = 0;

  logic          ws_arr [MAXT];
  logic [NL-1:0] sd_arr [MAXT];
  int            tlen;
  int            nl_a [8];
  int            nr_a [8];
  logic [23:0]   exp_l [8][NL];
  logic [23:0]   exp_r [8][NL];
  int            nfr;
  int            vcnt, elen_cnt, esym_cnt;
  string         cur_req;

  always #(CLK_PERIOD/2) bck = ~bck;

  ser_audio_rx dut (
    .bck_i       (bck),
    .rst_ni      (rst_n),
    .ws_i        (ws),
    .sd_i        (sd),
    .cfg_lsbj_i  (lsbj),
    .cfg_wlen_i  (wlen),
    .smp_left_o  (smp_l),
    .smp_right_o (smp_r),
    .smp_valid_o (valid),
    .err_len_o   (elen),
    .err_sym_o   (esym)
  );

  task automatic check_eq(input string req, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mkword(input int s);
    return (32'(s) * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  task automatic do_reset(input bit fmt, input logic [1:0] wl);
    rst_n = 1'b0; ws = 1'b0; sd = '0; lsbj = fmt; wlen = wl;
    repeat (4) @(negedge bck);
    rst_n = 1'b1;
    repeat (3) @(negedge bck);
  endtask

  // Lay out a bit stream: a dummy high half, nframes frames, a dummy low half.
  task automatic build(input bit fmt, input int txw, input int w,
                       input int nframes, input int scn);
    int t;
    for (int i = 0; i < MAXT; i++) begin ws_arr[i] = 1'b0; sd_arr[i] = '1; end
    t = 0;
    for (int i = 0; i < 8; i++) begin ws_arr[t] = 1'b1; t++; end
    for (int f = 0; f < nframes; f++) begin
      int sl, sr;
      sl = t;
      for (int i = 0; i < nl_a[f]; i++) begin ws_arr[t] = 1'b0; t++; end
      sr = t;
      for (int i = 0; i < nr_a[f]; i++) begin ws_arr[t] = 1'b1; t++; end
      for (int l = 0; l < NL; l++) begin
        for (int c = 0; c < 2; c++) begin
          logic [31:0] val, wtx, sel;
          int st, n;
          val = mkword(scn * 100 + f * 8 + l * 2 + c);
          wtx = (txw == 32) ? val : (val & ((32'd1 << txw) - 32'd1));
          st  = (c == 0) ? sl : sr;
          n   = (c == 0) ? nl_a[f] : nr_a[f];
          for (int k = 0; k < txw; k++) begin
            int pos;
            pos = fmt ? (st + n - txw + k) : (st + 1 + k);
            sd_arr[pos][l] = wtx[txw-1-k];
          end
          sel = fmt ? wtx : (wtx >> (txw - w));
          sel = sel & ((32'd1 << w) - 32'd1);
          if (c == 0) exp_l[f][l] = 24'(sel << (24 - w));
          else        exp_r[f][l] = 24'(sel << (24 - w));
        end
      end
    end
    for (int i = 0; i < 8; i++) begin ws_arr[t] = 1'b0; t++; end
    tlen = t;
    nfr  = nframes;
  endtask

  task automatic monitor();
    if (valid === 1'b1) begin
      if (vcnt < nfr) begin
        for (int l = 0; l < NL; l++) begin
          check_eq(cur_req, $sformatf("frame%0d line%0d left", vcnt, l),
                   32'(smp_l[l*24 +: 24]), 32'(exp_l[vcnt][l]));
          check_eq(cur_req, $sformatf("frame%0d line%0d right", vcnt, l),
                   32'(smp_r[l*24 +: 24]), 32'(exp_r[vcnt][l]));
        end
      end
      vcnt++;
    end
    if (elen === 1'b1) elen_cnt++;
    if (esym === 1'b1) esym_cnt++;
  endtask

  task automatic play();
    vcnt = 0; elen_cnt = 0; esym_cnt = 0;
    for (int t = 0; t < tlen + 12; t++) begin
      @(negedge bck);
      monitor();
      if (t < tlen) begin ws = ws_arr[t]; sd = sd_arr[t]; end
      else          begin ws = 1'b0;      sd = '0;        end
    end
  endtask

  task automatic run_scn(input string req, input bit fmt, input logic [1:0] wl,
                         input int w, input int txw, input int nframes,
                         input int scn, input int exp_len, input int exp_sym);
    cur_req = req;
    do_reset(fmt, wl);
    build(fmt, txw, w, nframes, scn);
    play();
    check_eq("R8", {req, " valid pulse count"}, 32'(vcnt), 32'(nframes));
    check_eq("R9", {req, " length error count"}, 32'(elen_cnt), 32'(exp_len));
    check_eq("R10", {req, " symmetry error count"}, 32'(esym_cnt), 32'(exp_sym));
    repeat (20) @(negedge bck);
    // R11: outputs still hold the final frame, no further strobe
    check_eq("R11", {req, " hold line0 left"}, 32'(smp_l[23:0]), 32'(exp_l[nframes-1][0]));
    check_eq("R11", {req, " hold line3 right"}, 32'(smp_r[3*24 +: 24]), 32'(exp_r[nframes-1][3]));
    check_eq("R11", {req, " no stray valid"}, 32'(valid), 32'd0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; ws = 1'b1; sd = '1; lsbj = 1'b0; wlen = 2'd3;
    repeat (5) @(negedge bck);
    check_eq("R1", "left during reset", 32'(|smp_l), 32'd0);
    check_eq("R1", "right during reset", 32'(|smp_r), 32'd0);
    check_eq("R1", "strobes during reset", 32'({valid, elen, esym}), 32'd0);
    rst_n = 1'b1; ws = 1'b0;
    repeat (4) @(negedge bck);
    check_eq("R1", "strobes after release", 32'({valid, elen, esym}), 32'd0);
    check_eq("R1", "samples after release", 32'(|{smp_l, smp_r}), 32'd0);
  endtask

  task automatic t_i2s_24();   // R2 R4 R7 R8
    for (int f = 0; f < 3; f++) begin nl_a[f] = 32; nr_a[f] = 32; end
    run_scn("R2", 1'b0, 2'd3, 24, 24, 3, 1, 0, 0);
  endtask

  task automatic t_i2s_16_tight();   // R2 R4 R7: word fills the half exactly
    for (int f = 0; f < 2; f++) begin nl_a[f] = 16; nr_a[f] = 16; end
    run_scn("R4", 1'b0, 2'd0, 16, 16, 2, 2, 0, 0);
  endtask

  task automatic t_i2s_trunc();   // R5: 32-bit words, keep top 24
    for (int f = 0; f < 2; f++) begin nl_a[f] = 32; nr_a[f] = 32; end
    run_scn("R5", 1'b0, 2'd3, 24, 32, 2, 3, 0, 0);
  endtask

  task automatic t_lsbj_20();   // R3 R6: padding ones above the MSB are dropped
    for (int f = 0; f < 3; f++) begin nl_a[f] = 32; nr_a[f] = 32; end
    run_scn("R3", 1'b1, 2'd2, 20, 20, 3, 4, 0, 0);
  endtask

  task automatic t_lsbj_18();   // R4 R6
    for (int f = 0; f < 2; f++) begin nl_a[f] = 24; nr_a[f] = 24; end
    run_scn("R6", 1'b1, 2'd1, 18, 18, 2, 5, 0, 0);
  endtask

  task automatic t_len();   // R9: 256 accepted, 260 flagged once
    nl_a[0] = 128; nr_a[0] = 128;
    nl_a[1] = 130; nr_a[1] = 130;
    run_scn("R9", 1'b0, 2'd3, 24, 24, 2, 6, 1, 0);
  endtask

  task automatic t_sym();   // R10: unequal halves flagged only in LSB-justified
    nl_a[0] = 32; nr_a[0] = 32;
    nl_a[1] = 32; nr_a[1] = 34;
    nl_a[2] = 40; nr_a[2] = 40;
    run_scn("R10", 1'b1, 2'd3, 24, 24, 3, 7, 0, 1);
    nl_a[0] = 32; nr_a[0] = 34;
    nl_a[1] = 36; nr_a[1] = 32;
    run_scn("R10", 1'b0, 2'd3, 24, 24, 2, 8, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_i2s_24();
    t_i2s_16_tight();
    t_i2s_trunc();
    t_lsbj_20();
    t_lsbj_18();
    t_len();
    t_sym();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule